// File: doc/BRIEF.md
# Nibble-wide stack processor core

A multicycle processor whose data words are four bits wide and whose operands all live on an evaluation stack held in data memory. The core keeps an 8-bit program counter, an 8-bit top-of-stack pointer, an instruction register, an operand buffer and one scratch data register. Instruction memory and data memory are separate arrays outside the core. Both are read combinationally in the same cycle and written on the rising clock edge. Every instruction begins with a one-nibble opcode. It may carry one data nibble or two address nibbles (high nibble first), and then runs one or two execute cycles on the single data-memory port.

Arithmetic and logic operate only on the entries at the top of the stack. Pushing increments the stack pointer before the write, and popping decrements it after the read. A subroutine call stores the 8-bit return address as two stack entries, so a return can restore it. The program counter always points at the next instruction to fetch, and that is the value a call saves. A `hold` input lets a debugger stop the core cleanly at an instruction boundary. The PC, the stack pointer, the current opcode and a one-cycle retire pulse are visible at the ports.

Top module: `stk4_core`

## Requirements
- R1: While reset is low and directly after it, the PC reads 0 and the stack pointer reads 8'hFF, which denotes an empty stack.
- R2: Opcodes 0 (add), 1 (subtract), 2 (AND) and 3 (OR) combine the entry below the top (left operand) with the top entry (right operand), modulo 16. They write the result over the lower entry and lower the stack pointer by one. Subtract computes lower minus top.
- R3: Opcodes 4 (invert), 5 (increment modulo 16), 6 (rotate right, bit 0 into bit 3) and 7 (arithmetic shift right, bit 3 kept) rewrite the top entry in place and leave the stack pointer unchanged.
- R4: Opcode 8 is followed by one data nibble. It raises the stack pointer by one and then writes that nibble at the new top. The stack pointer only ever moves by one per cycle.
- R5: Opcode 9 is followed by an 8-bit data address, high nibble first; it pushes the word found at that address. Opcode 10 is followed by an address in the same form; it stores the top entry there and then lowers the stack pointer.
- R6: Opcode 13 branches to the 8-bit address that follows it when the top entry is zero. Opcode 14 branches there when bit 3 of the top entry is set. Otherwise execution falls through to the next instruction. Neither opcode changes the stack pointer or writes data memory.
- R7: Opcode 15 jumps unconditionally to the 8-bit address that follows it.
- R8: Opcode 11 pushes the return address low nibble first and then high nibble (stack pointer +2), and jumps to the 8-bit address that follows it. Opcode 12 pops the high nibble and then the low nibble (stack pointer −2) and resumes at that address.
- R9: The return address saved by opcode 11 equals the address just past its last nibble. The PC already holds this value during execution.
- R10: An instruction takes 1 + (operand nibbles) + (execute cycles) clocks. Execute takes two cycles for opcodes 0–3 and 9–12, and one cycle for the rest. `retire` is high only in the final execute cycle.
- R11: While `hold` is high at an instruction boundary, the core fetches nothing, raises `held`, and leaves the PC, the stack pointer and data memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| hold | input | 1 | Stop at the next instruction boundary |
| imem_addr | output | 8 | Instruction memory address (the PC) |
| imem_rdata | input | 4 | Instruction nibble read at imem_addr |
| dmem_addr | output | 8 | Data memory address |
| dmem_we | output | 1 | Data memory write enable |
| dmem_wdata | output | 4 | Data memory write value |
| dmem_rdata | input | 4 | Data word read at dmem_addr |
| pc | output | 8 | Program counter |
| tos | output | 8 | Top-of-stack pointer |
| held | output | 1 | Core is stopped at a boundary by hold |
| retire | output | 1 | Final execute cycle of an instruction |
| dbg_op | output | 4 | Opcode of the instruction in the register |

## Verification
The assertions take for granted that both memories answer a read in the same cycle the address appears. They also assume that reset is low from time zero, and that `hold` changes only between clock edges. The bench uses combinational-read memory models. It drives `hold` and reset only on falling edges and holds reset low at the start of every case. Each program it runs stays well clear of the 8-bit stack wrap and of its own code area, so the stack pointer moves only through pushes and pops.

// File: rtl/stk4_pkg.sv
package stk4_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'h0,
      OP_SUB   = 4'h1,
      OP_AND   = 4'h2,
      OP_OR    = 4'h3,
      OP_COMP  = 4'h4,
      OP_INCR  = 4'h5,
      OP_ROR   = 4'h6,
      OP_ASR   = 4'h7,
      OP_PUSHC = 4'h8,
      OP_PUSH  = 4'h9,
      OP_POP   = 4'hA,
      OP_JSR   = 4'hB,
      OP_RTS   = 4'hC,
      OP_BRZ   = 4'hD,
      OP_BRN   = 4'hE,
      OP_JMP   = 4'hF
   } opc_e;

   typedef enum logic [1:0] {
      PH_FETCH = 2'd0,
      PH_EXT   = 2'd1,
      PH_EXEC  = 2'd2
   } phase_e;

endpackage

// File: rtl/stk4_alu.sv
module stk4_alu
   import stk4_pkg::*;
#(
   parameter int DW = 4
) (
   input  logic [1:0]    sel,
   input  logic          unary,
   input  logic [DW-1:0] lhs,
   input  logic [DW-1:0] rhs,
   output logic [DW-1:0] res
);

   localparam logic [DW-1:0] D_ONE = {{(DW-1){1'b0}}, 1'b1};

   logic [DW-1:0] ror_v;
   logic [DW-1:0] asr_v;

   for (genvar i = 0; i < DW; i++) begin : g_shift
      if (i == DW-1) begin : g_msb
         assign ror_v[i] = lhs[0];
         assign asr_v[i] = lhs[DW-1];
      end else begin : g_low
         assign ror_v[i] = lhs[i+1];
         assign asr_v[i] = lhs[i+1];
      end
   end

   always_comb begin
      case ({unary, sel})
         3'b000:  res = lhs + rhs;
         3'b001:  res = lhs - rhs;
         3'b010:  res = lhs & rhs;
         3'b011:  res = lhs | rhs;
         3'b100:  res = ~lhs;
         3'b101:  res = lhs + D_ONE;
         3'b110:  res = ror_v;
         default: res = asr_v;
      endcase
   end

endmodule

// File: rtl/stk4_decode.sv
module stk4_decode
   import stk4_pkg::*;
(
   input  opc_e       op,
   output logic [1:0] n_ext,
   output logic       two_step,
   output logic       is_un
);

   always_comb begin
      n_ext    = 2'd0;
      two_step = 1'b0;
      is_un    = 1'b0;
      case (op)
         OP_ADD, OP_SUB, OP_AND, OP_OR: two_step = 1'b1;
         OP_COMP, OP_INCR, OP_ROR, OP_ASR: is_un = 1'b1;
         OP_PUSHC: n_ext = 2'd1;
         OP_PUSH, OP_POP, OP_JSR: begin
            n_ext    = 2'd2;
            two_step = 1'b1;
         end
         OP_RTS: two_step = 1'b1;
         OP_BRZ, OP_BRN, OP_JMP: n_ext = 2'd2;
         default: n_ext = 2'd0;
      endcase
   end

endmodule

// File: rtl/stk4_seq.sv
module stk4_seq
   import stk4_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold,
   input  logic [1:0] n_ext,
   input  logic       two_step,
   output phase_e     phase,
   output logic       step,
   output logic       fetch_en,
   output logic       ext_en,
   output logic       last,
   output logic       held
);

   logic ext_idx;

   assign fetch_en = (phase == PH_FETCH) && !hold;
   assign held     = (phase == PH_FETCH) && hold;
   assign ext_en   = (phase == PH_EXT);
   assign last     = (phase == PH_EXEC) && (step || !two_step);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_FETCH;
         ext_idx <= 1'b0;
         step    <= 1'b0;
      end else begin
         case (phase)
            PH_FETCH: begin
               ext_idx <= 1'b0;
               step    <= 1'b0;
               if (!hold) begin
                  phase <= (n_ext != 2'd0) ? PH_EXT : PH_EXEC;
               end
            end
            PH_EXT: begin
               if ({1'b0, ext_idx} == n_ext - 2'd1) begin
                  phase <= PH_EXEC;
                  step  <= 1'b0;
               end else begin
                  ext_idx <= 1'b1;
               end
            end
            PH_EXEC: begin
               if (last) begin
                  phase <= PH_FETCH;
                  step  <= 1'b0;
               end else begin
                  step <= 1'b1;
               end
            end
            default: phase <= PH_FETCH;
         endcase
      end
   end

endmodule

// File: rtl/stk4_core.sv
module stk4_core
   import stk4_pkg::*;
#(
   parameter int DW = 4,
   parameter int AW = 2 * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   output logic [AW-1:0] imem_addr,
   input  logic [DW-1:0] imem_rdata,
   output logic [AW-1:0] dmem_addr,
   output logic          dmem_we,
   output logic [DW-1:0] dmem_wdata,
   input  logic [DW-1:0] dmem_rdata,
   output logic [AW-1:0] pc,
   output logic [AW-1:0] tos,
   output logic          held,
   output logic          retire,
   output logic [3:0]    dbg_op
);

   localparam logic [AW-1:0] A_ONE = {{(AW-1){1'b0}}, 1'b1};

   if (DW < 4) begin : g_bad_dw
      $error("stk4_core: DW must be at least 4 to hold an opcode");
   end
   if (AW != 2 * DW) begin : g_bad_aw
      $error("stk4_core: AW must equal two data words");
   end

   logic [DW-1:0] ir;
   logic [AW-1:0] abuf;
   logic [DW-1:0] breg;
   logic [AW-1:0] pc_nx, tos_nx;
   logic [DW-1:0] breg_nx;
   logic [AW-1:0] tos_up, tos_dn;

   phase_e     phase;
   logic       step, fetch_en, ext_en;
   opc_e       ir_op, dec_op;
   logic [1:0] n_ext;
   logic       two_step, is_un;
   logic [DW-1:0] alu_res;

   assign ir_op  = opc_e'(ir[3:0]);
   assign dec_op = (phase == PH_FETCH) ? opc_e'(imem_rdata[3:0]) : ir_op;
   assign tos_up = tos + A_ONE;
   assign tos_dn = tos - A_ONE;

   stk4_decode u_dec (
      .op       (dec_op),
      .n_ext    (n_ext),
      .two_step (two_step),
      .is_un    (is_un)
   );

   stk4_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold),
      .n_ext    (n_ext),
      .two_step (two_step),
      .phase    (phase),
      .step     (step),
      .fetch_en (fetch_en),
      .ext_en   (ext_en),
      .last     (retire),
      .held     (held)
   );

   stk4_alu #(.DW(DW)) u_alu (
      .sel   (ir[1:0]),
      .unary (is_un),
      .lhs   (dmem_rdata),
      .rhs   (breg),
      .res   (alu_res)
   );

   always_comb begin
      pc_nx      = pc;
      tos_nx     = tos;
      breg_nx    = breg;
      dmem_addr  = tos;
      dmem_we    = 1'b0;
      dmem_wdata = alu_res;
      if (fetch_en || ext_en) begin
         pc_nx = pc + A_ONE;
      end
      if (phase == PH_EXEC) begin
         case (ir_op)
            OP_ADD, OP_SUB, OP_AND, OP_OR: begin
               if (!step) begin
                  breg_nx = dmem_rdata;
               end else begin
                  dmem_addr = tos_dn;
                  dmem_we   = 1'b1;
                  tos_nx    = tos_dn;
               end
            end
            OP_COMP, OP_INCR, OP_ROR, OP_ASR: dmem_we = 1'b1;
            OP_PUSHC: begin
               dmem_addr  = tos_up;
               dmem_we    = 1'b1;
               dmem_wdata = abuf[DW-1:0];
               tos_nx     = tos_up;
            end
            OP_PUSH: begin
               if (!step) begin
                  dmem_addr = abuf;
                  breg_nx   = dmem_rdata;
               end else begin
                  dmem_addr  = tos_up;
                  dmem_we    = 1'b1;
                  dmem_wdata = breg;
                  tos_nx     = tos_up;
               end
            end
            OP_POP: begin
               if (!step) begin
                  breg_nx = dmem_rdata;
               end else begin
                  dmem_addr  = abuf;
                  dmem_we    = 1'b1;
                  dmem_wdata = breg;
                  tos_nx     = tos_dn;
               end
            end
            OP_JSR: begin
               dmem_addr  = tos_up;
               dmem_we    = 1'b1;
               tos_nx     = tos_up;
               dmem_wdata = step ? pc[AW-1:DW] : pc[DW-1:0];
               if (step) begin
                  pc_nx = abuf;
               end
            end
            OP_RTS: begin
               tos_nx = tos_dn;
               if (!step) begin
                  breg_nx = dmem_rdata;
               end else begin
                  pc_nx = {breg, dmem_rdata};
               end
            end
            OP_BRZ: if (dmem_rdata == '0) pc_nx = abuf;
            OP_BRN: if (dmem_rdata[DW-1]) pc_nx = abuf;
            OP_JMP: pc_nx = abuf;
            default: pc_nx = pc;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc   <= '0;
         tos  <= '1;
         ir   <= '0;
         abuf <= '0;
         breg <= '0;
      end else begin
         pc   <= pc_nx;
         tos  <= tos_nx;
         breg <= breg_nx;
         if (fetch_en) begin
            ir <= imem_rdata;
         end
         if (ext_en) begin
            abuf <= {abuf[DW-1:0], imem_rdata};
         end
      end
   end

   assign imem_addr = pc;
   assign dbg_op    = ir[3:0];

endmodule

// File: rtl/stk4_core_chk.sv
module stk4_core_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] pc,
   input logic [AW-1:0] tos,
   input logic          held,
   input logic          retire,
   input logic [3:0]    dbg_op,
   input logic          dmem_we
);

   logic is_branch;
   assign is_branch = (dbg_op == 4'hD) || (dbg_op == 4'hE);

   AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (pc == '0 && tos == '1)); // R1

   AST_TOS_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tos != $past(tos)) |-> (tos == $past(tos) + 1'b1 || tos == $past(tos) - 1'b1)); // R4

   AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && is_branch) |-> !dmem_we); // R6

   AST_BRANCH_KEEPS_TOS: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && is_branch) |=> (tos == $past(tos))); // R6

   AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> !retire); // R10

   AST_HELD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      held |=> (pc == $past(pc) && tos == $past(tos))); // R11

   AST_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> !dmem_we); // R11

endmodule

bind stk4_core stk4_core_chk #(.AW(AW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pc      (pc),
   .tos     (tos),
   .held    (held),
   .retire  (retire),
   .dbg_op  (dbg_op),
   .dmem_we (dmem_we)
);

// File: tb/tb_stk4_core.sv
module tb_stk4_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hold = 1'b1;
   logic [7:0] imem_addr, dmem_addr, pc, tos;
   logic [3:0] imem_rdata, dmem_wdata, dmem_rdata, dbg_op;
   logic       dmem_we, held, retire;

   logic [3:0] imem [0:255];
   logic [3:0] dmem [0:255];

   int n_chk = 0;
   int n_fail = 0;
   int cyc_total = 0;

   always #5 clk = ~clk;

   assign imem_rdata = imem[imem_addr];
   assign dmem_rdata = dmem[dmem_addr];

   always @(posedge clk) begin
      if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
   end

   stk4_core dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold       (hold),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_we    (dmem_we),
      .dmem_wdata (dmem_wdata),
      .dmem_rdata (dmem_rdata),
      .pc         (pc),
      .tos        (tos),
      .held       (held),
      .retire     (retire),
      .dbg_op     (dbg_op)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL R10 watchdog: actual %0d cycles expected below 150000", cyc_total);
         summary();
         $finish;
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) begin
         imem[i] = 4'h0;
         dmem[i] = 4'h0;
      end
   endtask

   task automatic put(input int a, input int v);
      imem[a[7:0]] = v[3:0];
   endtask

   task automatic put_addr(input int a, input int op, input int tgt);
      put(a, op);
      put(a + 1, (tgt >> 4) & 15);
      put(a + 2, tgt & 15);
   endtask

   task automatic reset_core();
      hold  = 1'b1;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run(input int n, output int cycles);
      int seen;
      seen   = 0;
      cycles = 0;
      hold   = 1'b0;
      while (seen < n && cycles < 64) begin
         cycles++;
         if (retire) seen++;
         if (seen < n) @(negedge clk);
      end
      hold = 1'b1;
      if (seen < n) chk("R10 instruction never retired", seen, n);
      @(negedge clk);
   endtask

   function automatic int bin_ref(input int op, input int a, input int b);
      case (op)
         0: return (a + b) & 15;
         1: return (a - b) & 15;
         2: return a & b;
         default: return a | b;
      endcase
   endfunction

   function automatic int un_ref(input int op, input int x);
      case (op)
         4: return (~x) & 15;
         5: return (x + 1) & 15;
         6: return (x >> 1) | ((x & 1) << 3);
         default: return (x >> 1) | (x & 8);
      endcase
   endfunction

   initial begin
      int cyc;
      clear_mem();
      reset_core();

      // R1 reset state, R11 hold freezes the core
      chk("R1 pc after reset", pc, 0);
      chk("R1 tos after reset", tos, 255);
      chk("R11 held while hold high", held, 1);
      repeat (4) @(negedge clk);
      chk("R11 pc frozen by hold", pc, 0);
      chk("R11 tos frozen by hold", tos, 255);

      // R2 exhaustive binary sweep
      for (int op = 0; op < 4; op++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               clear_mem();
               put(0, 8); put(1, a); put(2, 8); put(3, b); put(4, op);
               reset_core();
               run(3, cyc);
               chk($sformatf("R2 op%0d a=%0d b=%0d result", op, a, b), dmem[0], bin_ref(op, a, b));
               chk("R2 tos after binary op", tos, 0);
            end
         end
      end

      // R3 unary sweep, R4 push-constant pre-increment
      for (int op = 4; op < 8; op++) begin
         for (int x = 0; x < 16; x++) begin
            clear_mem();
            put(0, 8); put(1, x); put(2, op);
            reset_core();
            run(1, cyc);
            chk("R4 tos after push constant", tos, 0);
            chk("R4 value at new top", dmem[0], x);
            run(1, cyc);
            chk($sformatf("R3 op%0d x=%0d result", op, x), dmem[0], un_ref(op, x));
            chk("R3 tos unchanged", tos, 0);
         end
      end

      // R5 push from / pop to memory
      for (int c = 0; c < 16; c++) begin
         int src, dst;
         src = 16 * c + (15 - c);
         dst = src ^ 8'hA5;
         clear_mem();
         dmem[src[7:0]] = c[3:0];
         put_addr(0, 9, src);
         put_addr(3, 10, dst);
         reset_core();
         run(1, cyc);
         chk("R5 tos after push", tos, 0);
         chk("R5 pushed value", dmem[0], c);
         run(1, cyc);
         chk("R5 popped value at target", dmem[dst[7:0]], c);
         chk("R5 tos after pop", tos, 255);
      end

      // R6 conditional branches
      for (int kind = 13; kind < 15; kind++) begin
         for (int v = 0; v < 16; v++) begin
            int taken;
            taken = (kind == 13) ? (v == 0) : (v >= 8);
            clear_mem();
            put(0, 8); put(1, v);
            put_addr(2, kind, 8'h20);
            reset_core();
            run(2, cyc);
            chk($sformatf("R6 op%0d v=%0d pc", kind, v), pc, taken ? 8'h20 : 5);
            chk("R6 tos unchanged by branch", tos, 0);
            chk("R6 stack entry unchanged", dmem[0], v);
         end
      end

      // R7 unconditional jump
      for (int k = 0; k < 14; k++) begin
         int t;
         t = 8'h10 + 17 * k;
         clear_mem();
         put_addr(0, 15, t);
         put(t, 8); put(t + 1, k);
         reset_core();
         run(1, cyc);
         chk("R7 pc after jump", pc, t);
         run(1, cyc);
         chk("R7 code at target executed", dmem[0], k);
      end

      // R8 call/return, R9 saved address is the one past the call
      for (int k = 0; k < 13; k++) begin
         int l, t, r;
         l = 8'h10 + 13 * k;
         t = (l + 8'h80) & 255;
         r = l + 3;
         clear_mem();
         put_addr(0, 15, l);
         put_addr(l, 11, t);
         put(t, 12);
         reset_core();
         run(2, cyc);
         chk("R8 pc after call", pc, t);
         chk("R8 tos after call", tos, 1);
         chk("R9 saved low nibble", dmem[0], r & 15);
         chk("R9 saved high nibble", dmem[1], r >> 4);
         run(1, cyc);
         chk("R8 pc after return", pc, r);
         chk("R8 tos after return", tos, 255);
      end

      // R10 cycle count per opcode
      for (int op = 0; op < 16; op++) begin
         int ext, exe;
         ext = (op < 8 || op == 12) ? 0 : ((op == 8) ? 1 : 2);
         exe = (op < 4 || (op >= 9 && op <= 12)) ? 2 : 1;
         clear_mem();
         put(0, op); put(1, 3); put(2, 0);
         dmem[255] = 4'h2;
         reset_core();
         run(1, cyc);
         chk($sformatf("R10 cycles for op%0d", op), cyc, 1 + ext + exe);
         chk("R10 retire low after instruction", retire, 0);
      end

      summary();
      $finish;
   end

endmodule